// File: doc/BRIEF.md
# Serial Control Word Register Port

This block receives 16-bit command words over a three-wire serial control link and holds the configuration of a six-channel audio converter. The link carries a control clock, a data line and a latch strobe. Bits arrive most significant first and are taken on each rising edge of the control clock. A word is committed to a register only when the latch strobe rises, and only if exactly 16 clock edges came before it.

The top four bits of a word pick the target register. The next two bits are reserved. The low ten bits are the register contents. Nine addresses are defined: three control registers and six per-channel volume registers. The other seven addresses are ignored. Every decoded field is brought out as a parallel output: word length, serial format, power-down, interpolation rate, de-emphasis, per-channel mute, stereo copy, clock multiplier, zero-flag polarity, TDM master/slave and the six volumes.

The link pins are asynchronous to the block. They pass through a synchronizer into the system clock domain, and the block finds their edges there. The system clock must therefore run several times faster than the control clock.

Top module: `ctlp_top`

## Requirements
- R1: After reset, all control fields and mutes read 0 and every volume reads all ones (10'h3FF, no attenuation).
- R2: A word is shifted in most significant bit first, one bit per rising edge of `ctl_sclk`, and `ctl_sdat` is taken at that edge.
- R3: A word is committed only on a rising edge of `ctl_latch` preceded by exactly 16 rising edges of `ctl_sclk` since the previous latch rise. Any other count, including 0, 15 and 17, discards the word. The count restarts at every latch rise.
- R4: Word bits 15..12 form the address. 4'h0 selects control 1, 4'h1 selects control 2, 4'h2..4'h7 select volume 1..6, and 4'h8 selects control 3. Bits 9..0 are written to the selected register.
- R5: A word with address 4'h9..4'hF changes no output.
- R6: Control 1 fields: bits 9..8 are de-emphasis, bits 7..5 the serial format, bits 4..3 the word length, bit 2 power-down and bits 1..0 the interpolation rate.
- R7: Control 2 bit n-1 mutes channel n (1 = muted) for n = 1..6. Bits 9..6 do not reach any output.
- R8: Control 3 fields: bit 5 is stereo copy, bits 4..3 the clock multiplier code (00 = x2, 01 = x1, 10 = x2/3), bit 2 the zero-flag polarity (1 = active low) and bit 0 TDM slave (1 = slave).
- R9: A register keeps its value until a committed word addresses it. A commit changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial control clock (asynchronous) |
| ctl_sdat | input | 1 | Serial control data, MSB first |
| ctl_latch | input | 1 | Latch strobe; rising edge commits the word |
| deemph_sel | output | 2 | De-emphasis curve code |
| fmt_sel | output | 3 | Serial audio format code |
| wlen_sel | output | 2 | Audio word length code |
| pwr_down | output | 1 | Power-down request |
| interp_sel | output | 2 | Interpolation rate code |
| ch_mute | output | 6 | Per-channel mute, bit 0 = channel 1 |
| stereo_copy | output | 1 | Copy channel pair 1 onto the other pairs |
| mclk_mul | output | 2 | Master clock multiplier code |
| zero_act_low | output | 1 | Zero flag polarity, 1 = active low |
| tdm_slave | output | 1 | TDM timing slave select |
| vol_flat | output | 60 | Six 10-bit volumes, volume 1 in bits 9..0 |

## Verification
Assertions check three things on every cycle. The commit strobe is a single-cycle pulse, and the edge counter clears after each latch rise. A cycle without a commit, or a commit to a reserved address, leaves every register unchanged. A commit to control 1 or to any volume address loads exactly the word's data. The bench scenarios show the rest, which depends on the serial waveform as a whole: MSB-first bit ordering, rejection of 15-, 17- and zero-edge writes, the field positions in each control register, masking of the mute register's spare bits, and restoration of the reset defaults in the middle of a run.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;
   // Word layout (MSB first on the wire)
   localparam int CTLP_ADDR_W = 4;
   localparam int CTLP_RSV_W  = 2;
   localparam int CTLP_DATA_W = 10;
   localparam int CTLP_WORD_W = CTLP_ADDR_W + CTLP_RSV_W + CTLP_DATA_W;

   // Address map; volume n lives at VOL_BASE + n - 1
   localparam logic [CTLP_ADDR_W-1:0] ADR_CTL1     = 4'h0;
   localparam logic [CTLP_ADDR_W-1:0] ADR_CTL2     = 4'h1;
   localparam logic [CTLP_ADDR_W-1:0] ADR_VOL_BASE = 4'h2;
   localparam logic [CTLP_ADDR_W-1:0] ADR_CTL3     = 4'h8;

   // Control 1 field positions
   localparam int C1_DEEMPH_LSB = 8;
   localparam int C1_FMT_LSB    = 5;
   localparam int C1_WLEN_LSB   = 3;
   localparam int C1_PD_BIT     = 2;
   localparam int C1_INTERP_LSB = 0;

   // Control 3 field positions
   localparam int C3_COPY_BIT  = 5;
   localparam int C3_MUL_LSB   = 3;
   localparam int C3_ZPOL_BIT  = 2;
   localparam int C3_SLAVE_BIT = 0;
endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ctlp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ctlp_shift.sv
module ctlp_shift #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              slat_s,
   output logic [WORD_W-1:0] word_q,
   output logic              commit_q
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   logic              sclk_d, slat_d;
   logic              sclk_rise, lat_rise;
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  edge_cnt;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign lat_rise  = slat_s & ~slat_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         slat_d   <= 1'b0;
         shreg    <= '0;
         edge_cnt <= '0;
         word_q   <= '0;
         commit_q <= 1'b0;
      end else begin
         sclk_d   <= sclk_s;
         slat_d   <= slat_s;
         commit_q <= 1'b0;
         if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdat_s};
         if (lat_rise) begin
            commit_q <= (edge_cnt == CNT_FULL);
            word_q   <= shreg;
            edge_cnt <= '0;
         end else if (sclk_rise && edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

   // R3
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |=> !commit_q);
   // R3
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rise |=> (edge_cnt == '0));
endmodule

// File: rtl/ctlp_regfile.sv
module ctlp_regfile
   import ctlp_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 10,
   parameter int NUM_VOL = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         data,
   output logic [DATA_W-1:0]         ctl1_q,
   output logic [DATA_W-1:0]         ctl2_q,
   output logic [DATA_W-1:0]         ctl3_q,
   output logic [NUM_VOL*DATA_W-1:0] vol_flat
);
   localparam logic [DATA_W-1:0] VOL_RESET = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl1_q <= '0;
         ctl2_q <= '0;
         ctl3_q <= '0;
      end else if (wr) begin
         if (addr == ADR_CTL1) ctl1_q <= data;
         if (addr == ADR_CTL2) ctl2_q <= data;
         if (addr == ADR_CTL3) ctl3_q <= data;
      end
   end

   generate
      for (genvar v = 0; v < NUM_VOL; v++) begin : g_vol
         localparam logic [ADDR_W-1:0] MY_ADR = ADR_VOL_BASE + ADDR_W'(v);
         logic [DATA_W-1:0] vol_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    vol_q <= VOL_RESET;
            else if (wr && addr == MY_ADR) vol_q <= data;
         end
         assign vol_flat[v*DATA_W +: DATA_W] = vol_q;

         // R4
         vol_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == MY_ADR) |=> (vol_flat[v*DATA_W +: DATA_W] == $past(data)));
      end
   endgenerate

   // R6
   ctl1_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADR_CTL1) |=> (ctl1_q == $past(data)));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(ctl1_q) && $stable(ctl2_q) && $stable(ctl3_q) && $stable(vol_flat)));
   // R5
   rsv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr > ADR_CTL3) |=>
         ($stable(ctl1_q) && $stable(ctl2_q) && $stable(ctl3_q) && $stable(vol_flat)));
endmodule

// File: rtl/ctlp_top.sv
module ctlp_top
   import ctlp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = CTLP_ADDR_W,
   parameter int DATA_W      = CTLP_DATA_W,
   parameter int NUM_VOL     = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctl_sclk,
   input  logic                      ctl_sdat,
   input  logic                      ctl_latch,
   output logic [1:0]                deemph_sel,
   output logic [2:0]                fmt_sel,
   output logic [1:0]                wlen_sel,
   output logic                      pwr_down,
   output logic [1:0]                interp_sel,
   output logic [NUM_VOL-1:0]        ch_mute,
   output logic                      stereo_copy,
   output logic [1:0]                mclk_mul,
   output logic                      zero_act_low,
   output logic                      tdm_slave,
   output logic [NUM_VOL*DATA_W-1:0] vol_flat
);
   localparam int WORD_W = ADDR_W + CTLP_RSV_W + DATA_W;

   generate
      if (ADDR_W != CTLP_ADDR_W) begin : g_bad_addr
         $error("ctlp_top: address width must match the address map");
      end
      if (DATA_W < CTLP_DATA_W) begin : g_bad_data
         $error("ctlp_top: data width too narrow for the control fields");
      end
      if (NUM_VOL < 1 || NUM_VOL > 6) begin : g_bad_vol
         $error("ctlp_top: NUM_VOL must be 1..6 to fit the address map");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic [WORD_W-1:0] word;
   logic              commit;
   logic [DATA_W-1:0] ctl1_q, ctl2_q, ctl3_q;

   ctlp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ctl_latch, ctl_sdat, ctl_sclk}),
      .q_sync  (pins_s)
   );

   ctlp_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (pins_s[0]),
      .sdat_s   (pins_s[1]),
      .slat_s   (pins_s[2]),
      .word_q   (word),
      .commit_q (commit)
   );

   ctlp_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_VOL(NUM_VOL)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (commit),
      .addr     (word[WORD_W-1 -: ADDR_W]),
      .data     (word[DATA_W-1:0]),
      .ctl1_q   (ctl1_q),
      .ctl2_q   (ctl2_q),
      .ctl3_q   (ctl3_q),
      .vol_flat (vol_flat)
   );

   assign deemph_sel   = ctl1_q[C1_DEEMPH_LSB +: 2];
   assign fmt_sel      = ctl1_q[C1_FMT_LSB +: 3];
   assign wlen_sel     = ctl1_q[C1_WLEN_LSB +: 2];
   assign pwr_down     = ctl1_q[C1_PD_BIT];
   assign interp_sel   = ctl1_q[C1_INTERP_LSB +: 2];
   assign ch_mute      = ctl2_q[NUM_VOL-1:0];
   assign stereo_copy  = ctl3_q[C3_COPY_BIT];
   assign mclk_mul     = ctl3_q[C3_MUL_LSB +: 2];
   assign zero_act_low = ctl3_q[C3_ZPOL_BIT];
   assign tdm_slave    = ctl3_q[C3_SLAVE_BIT];

   logic unused_bits;
   assign unused_bits = ^{ctl2_q[DATA_W-1:NUM_VOL], ctl3_q[1], ctl3_q[DATA_W-1:6],
                          word[DATA_W +: CTLP_RSV_W]};
endmodule

// File: tb/tb_ctlp_top.sv
module tb_ctlp_top;
   localparam int HALF = 3;
   localparam int NV   = 15;

   typedef struct packed {
      logic [15:0] w;
      logic [4:0]  nb;
      logic [3:0]  req;
   } vec_t;

   // word, edge count, requirement tag number
   localparam vec_t VECS [NV] = '{
      '{16'h01B5, 5'd16, 4'd6},   // R6 control 1 fields
      '{16'h102A, 5'd16, 4'd7},   // R7 mutes 2,4,6
      '{16'h8035, 5'd16, 4'd8},   // R8 copy, x2/3, active low, slave
      '{16'h2000, 5'd16, 4'd4},   // R4 volume 1
      '{16'h3155, 5'd16, 4'd4},   // R4 volume 2
      '{16'h42AA, 5'd16, 4'd4},   // R4 volume 3
      '{16'h5001, 5'd16, 4'd2},   // R2 MSB-first: volume 4 = 1
      '{16'h63FE, 5'd16, 4'd4},   // R4 volume 5
      '{16'h7200, 5'd16, 4'd2},   // R2 volume 6 = 0x200
      '{16'h93FF, 5'd16, 4'd5},   // R5 reserved address
      '{16'hF000, 5'd16, 4'd5},   // R5 reserved address
      '{16'h00FF, 5'd15, 4'd3},   // R3 15 edges discarded
      '{16'h1011, 5'd17, 4'd3},   // R3 17 edges discarded
      '{16'h13FF, 5'd16, 4'd7},   // R7 spare bits masked
      '{16'h0000, 5'd16, 4'd9}    // R9 only control 1 changes
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_sclk = 1'b0, ctl_sdat = 1'b0, ctl_latch = 1'b0;
   logic [1:0] deemph_sel, wlen_sel, interp_sel, mclk_mul;
   logic [2:0] fmt_sel;
   logic       pwr_down, stereo_copy, zero_act_low, tdm_slave;
   logic [5:0] ch_mute;
   logic [59:0] vol_flat;

   int checks = 0;
   int failures = 0;

   logic [9:0] m_c1, m_c2, m_c3;
   logic [9:0] m_v [6];

   always #5 clk = ~clk;

   ctlp_top dut (
      .clk(clk), .rst_n(rst_n), .ctl_sclk(ctl_sclk), .ctl_sdat(ctl_sdat),
      .ctl_latch(ctl_latch), .deemph_sel(deemph_sel), .fmt_sel(fmt_sel),
      .wlen_sel(wlen_sel), .pwr_down(pwr_down), .interp_sel(interp_sel),
      .ch_mute(ch_mute), .stereo_copy(stereo_copy), .mclk_mul(mclk_mul),
      .zero_act_low(zero_act_low), .tdm_slave(tdm_slave), .vol_flat(vol_flat)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_c1 = '0; m_c2 = '0; m_c3 = '0;
      for (int v = 0; v < 6; v++) m_v[v] = 10'h3FF;
   endtask

   task automatic model_write(input logic [15:0] w, input int nb);
      if (nb == 16) begin
         case (w[15:12])
            4'h0: m_c1 = w[9:0];
            4'h1: m_c2 = w[9:0];
            4'h8: m_c3 = w[9:0];
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7: m_v[w[15:12] - 4'h2] = w[9:0];
            default: ;
         endcase
      end
   endtask

   task automatic check_all(input string req);
      check(req, "deemph", deemph_sel, m_c1[9:8]);
      check(req, "fmt", fmt_sel, m_c1[7:5]);
      check(req, "wlen", wlen_sel, m_c1[4:3]);
      check(req, "pwr_down", pwr_down, m_c1[2]);
      check(req, "interp", interp_sel, m_c1[1:0]);
      check(req, "mute", ch_mute, m_c2[5:0]);
      check(req, "copy", stereo_copy, m_c3[5]);
      check(req, "mclk_mul", mclk_mul, m_c3[4:3]);
      check(req, "zero_pol", zero_act_low, m_c3[2]);
      check(req, "tdm_slave", tdm_slave, m_c3[0]);
      for (int v = 0; v < 6; v++)
         check(req, $sformatf("vol%0d", v + 1), vol_flat[v*10 +: 10], m_v[v]);
   endtask

   task automatic ser_write(input logic [15:0] w, input int nb);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk);
         ctl_sdat = (i < 16) ? w[15-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         ctl_sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         ctl_sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      ctl_latch = 1'b1;
      repeat (10) @(negedge clk);
      ctl_latch = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R1 reset state
      check_all("R1");

      for (int k = 0; k < NV; k++) begin
         ser_write(VECS[k].w, int'(VECS[k].nb));
         model_write(VECS[k].w, int'(VECS[k].nb));
         check_all($sformatf("R%0d", VECS[k].req));
      end

      // R3 latch with no clock edges is discarded
      ser_write(16'h0000, 0);
      check_all("R3");
      // R3 count restarts: a proper write right after a discard works
      ser_write(16'h0049, 17);
      ser_write(16'h0049, 16);
      model_write(16'h0049, 16);
      check_all("R3");
      // R8 multiplier x1 and master
      ser_write(16'h800C, 16);
      model_write(16'h800C, 16);
      check_all("R8");

      // R1 reset in mid-run restores defaults
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (2) @(negedge clk);
      check_all("R1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule